// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block turns a physical address into one of eight chip-select lines for an external bus. Each channel holds three programmable values: a 12-bit window base that lines up with address bits 31:20, a 4-bit size code, and an enable bit. A channel claims an access when the upper address bits agree with its base in every position that its size does not mask off. The size code expands into a run of low-order mask bits, so windows are naturally aligned powers of two from 1 MB up to 1 GB. Address bits 19:0 never take part in the compare.

Each access is offered for one cycle on `acc_valid` together with `acc_addr`. The block has no back-pressure: it accepts an access in every cycle, and `acc_valid` needs no ready partner. The result appears on `cs_sel` and `cs_conflict` one clock later. Two situations have no safe outcome on the bus. The first is two channels claiming the same access. The second is a channel claiming an access that the external memory controller or PCI controller also claims, signalled on `ext_mem_sel` and `ext_pci_sel`. In either case the block raises `cs_conflict` and drives no channel select at all.

Configuration goes through an indexed port. `cfg_idx` picks the channel. A write stores the base, size and enable values. The read outputs always show the stored values of the channel that `cfg_idx` picks.

Top module: `cs_addr_decoder`

## Requirements
- R1: A channel matches when acc_addr[31:20] equals its base in every bit where its mask is 0. Address bits 19:0 are ignored.
- R2: Size code n (0..10) covers 2^n MB. The mask has its n lowest bits set: code 0 gives an all-zero mask and code 10 gives mask bits for address 29:20.
- R3: A channel with a size code from 11 to 15 never asserts its select.
- R4: A channel whose enable bit is 0 never asserts its select. After reset every channel reads back base 0, size 0 and enable 0.
- R5: An access offered with acc_valid high in cycle N sets cs_sel and cs_conflict after the clock edge that ends cycle N. After any edge where acc_valid was low, both outputs are 0. cs_sel bit i belongs to channel i, and at most one bit is ever set.
- R6: When two or more channels match, cs_conflict is 1 and cs_sel is all zero.
- R7: When a channel matches while ext_mem_sel or ext_pci_sel is high, cs_conflict is 1 and cs_sel is all zero. External selects with no channel match give no conflict.
- R8: When cfg_we is high at an edge, the base, size and enable of channel cfg_idx are stored. cfg_rbase, cfg_rsize and cfg_ren show channel cfg_idx without delay. An access in the same cycle as a write is decoded with the configuration from before the write.
- R9: Synchronous reset (rst high at an edge) clears cs_sel, cs_conflict and all channel configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Channel index for write and read-back |
| cfg_wbase | input | 12 | Base to write (address bits 31:20) |
| cfg_wsize | input | 4 | Size code to write |
| cfg_wen | input | 1 | Enable bit to write |
| cfg_rbase | output | 12 | Stored base of channel cfg_idx |
| cfg_rsize | output | 4 | Stored size code of channel cfg_idx |
| cfg_ren | output | 1 | Stored enable of channel cfg_idx |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_addr | input | 32 | Physical address of the access |
| ext_mem_sel | input | 1 | External memory controller claims this access |
| ext_pci_sel | input | 1 | PCI controller claims this access |
| cs_sel | output | 8 | Registered one-hot channel selects |
| cs_conflict | output | 1 | Registered conflict flag |

## Verification
The hardest situation to reach is an overlap that only the mask creates. A large window hides a small one inside it, and the two bases differ only in bits that the larger size code ignores. The stimulus sets up a 16 MB channel and then places a 1 MB channel inside it at a different base. It probes the shared megabyte and a megabyte that belongs only to the large window. A second hard case is a configuration write and an access in the same cycle to the channel being written. The bench drives both strobes on one edge and expects the old, disabled configuration to decide that access.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
  localparam int ADDR_W   = 32;
  localparam int PAGE_LSB = 20;
  localparam int BASE_W   = ADDR_W - PAGE_LSB;
  localparam int SIZE_W   = 4;

  typedef struct packed {
    logic              en;
    logic [SIZE_W-1:0] size;
    logic [BASE_W-1:0] base;
  } ch_cfg_t;
endpackage

// File: rtl/csdec_mask_gen.sv
// Expands a size code into a low-order ones mask over the page bits and
// flags whether the code lies in the legal range.
module csdec_mask_gen #(
  parameter int MASK_W   = 12,
  parameter int CODE_W   = 4,
  parameter int CODE_MAX = 10
) (
  input  logic [CODE_W-1:0] code,
  output logic [MASK_W-1:0] mask,
  output logic              legal
);
  for (genvar g = 0; g < MASK_W; g++) begin : g_bit
    assign mask[g] = (32'(code) > g);
  end
  assign legal = (32'(code) <= CODE_MAX);
endmodule

// File: rtl/csdec_channel.sv
// One channel: configuration storage plus the masked window compare.
module csdec_channel
  import csdec_pkg::*;
#(
  parameter int SIZE_MAX = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  ch_cfg_t           wdata,
  input  logic [BASE_W-1:0] page,
  output ch_cfg_t           cfg,
  output logic              hit
);
  ch_cfg_t           cfg_q;
  logic [BASE_W-1:0] mask;
  logic              legal;

  always_ff @(posedge clk) begin
    if (rst)     cfg_q <= '0;
    else if (wr) cfg_q <= wdata;
  end

  csdec_mask_gen #(
    .MASK_W  (BASE_W),
    .CODE_W  (SIZE_W),
    .CODE_MAX(SIZE_MAX)
  ) u_mask (
    .code (cfg_q.size),
    .mask (mask),
    .legal(legal)
  );

  assign hit = cfg_q.en && legal && (((page ^ cfg_q.base) & ~mask) == '0);
  assign cfg = cfg_q;
endmodule

// File: rtl/csdec_resolve.sv
// Folds per-channel hits and external claims into registered selects.
module csdec_resolve #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid,
  input  logic [N-1:0] hit,
  input  logic         ext_claim,
  output logic [N-1:0] sel,
  output logic         conflict
);
  logic any_hit;
  logic multi_hit;
  logic clash;

  always_comb begin
    any_hit   = 1'b0;
    multi_hit = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) begin
        multi_hit = multi_hit | any_hit;
        any_hit   = 1'b1;
      end
    end
    clash = multi_hit || (any_hit && ext_claim);
  end

  always_ff @(posedge clk) begin
    if (rst || !valid) begin
      sel      <= '0;
      conflict <= 1'b0;
    end else begin
      sel      <= clash ? '0 : hit;
      conflict <= clash;
    end
  end
endmodule

// File: rtl/cs_addr_decoder.sv
module cs_addr_decoder
  import csdec_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int SIZE_MAX = 10,
  localparam int IDX_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [BASE_W-1:0] cfg_wbase,
  input  logic [SIZE_W-1:0] cfg_wsize,
  input  logic              cfg_wen,
  output logic [BASE_W-1:0] cfg_rbase,
  output logic [SIZE_W-1:0] cfg_rsize,
  output logic              cfg_ren,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              ext_mem_sel,
  input  logic              ext_pci_sel,
  output logic [NUM_CH-1:0] cs_sel,
  output logic              cs_conflict
);
  ch_cfg_t           wdata;
  ch_cfg_t           cfg_all [NUM_CH];
  logic [NUM_CH-1:0] hit;
  logic [BASE_W-1:0] page;

  assign wdata = '{en: cfg_wen, size: cfg_wsize, base: cfg_wbase};
  assign page  = acc_addr[ADDR_W-1:PAGE_LSB];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    csdec_channel #(.SIZE_MAX(SIZE_MAX)) u_ch (
      .clk  (clk),
      .rst  (rst),
      .wr   (cfg_we && (cfg_idx == IDX_W'(c))),
      .wdata(wdata),
      .page (page),
      .cfg  (cfg_all[c]),
      .hit  (hit[c])
    );
  end

  assign cfg_rbase = cfg_all[cfg_idx].base;
  assign cfg_rsize = cfg_all[cfg_idx].size;
  assign cfg_ren   = cfg_all[cfg_idx].en;

  csdec_resolve #(.N(NUM_CH)) u_res (
    .clk      (clk),
    .rst      (rst),
    .valid    (acc_valid),
    .hit      (hit),
    .ext_claim(ext_mem_sel || ext_pci_sel),
    .sel      (cs_sel),
    .conflict (cs_conflict)
  );
endmodule

// File: rtl/cs_addr_decoder_chk.sv
module cs_addr_decoder_chk #(
  parameter int NUM_CH = 8,
  parameter int IDX_W  = 3,
  parameter int BASE_W = 12,
  parameter int SIZE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [IDX_W-1:0]  cfg_idx,
  input logic [BASE_W-1:0] cfg_wbase,
  input logic [SIZE_W-1:0] cfg_wsize,
  input logic              cfg_wen,
  input logic [BASE_W-1:0] cfg_rbase,
  input logic [SIZE_W-1:0] cfg_rsize,
  input logic              cfg_ren,
  input logic              acc_valid,
  input logic              ext_mem_sel,
  input logic              ext_pci_sel,
  input logic [NUM_CH-1:0] cs_sel,
  input logic              cs_conflict
);
  // R5: never more than one select
  a_r5_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs_sel));

  // R5: no access, no outputs on the following cycle
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (cs_sel == '0 && !cs_conflict));

  // R6: a conflict never comes with a select
  a_r6_conflict_no_sel: assert property (@(posedge clk) disable iff (rst)
    cs_conflict |-> (cs_sel == '0));

  // R7: an external claim leaves every channel select low
  a_r7_ext_blocks: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && (ext_mem_sel || ext_pci_sel)) |=> (cs_sel == '0));

  // R8: a write is visible on read-back at the same index
  a_r8_readback: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> ((cfg_idx != $past(cfg_idx)) ||
                (cfg_rbase == $past(cfg_wbase) &&
                 cfg_rsize == $past(cfg_wsize) &&
                 cfg_ren   == $past(cfg_wen))));

  // R9: reset clears the outputs
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (cs_sel == '0 && !cs_conflict));
endmodule

bind cs_addr_decoder cs_addr_decoder_chk #(
  .NUM_CH(NUM_CH),
  .IDX_W (IDX_W),
  .BASE_W(csdec_pkg::BASE_W),
  .SIZE_W(csdec_pkg::SIZE_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_we     (cfg_we),
  .cfg_idx    (cfg_idx),
  .cfg_wbase  (cfg_wbase),
  .cfg_wsize  (cfg_wsize),
  .cfg_wen    (cfg_wen),
  .cfg_rbase  (cfg_rbase),
  .cfg_rsize  (cfg_rsize),
  .cfg_ren    (cfg_ren),
  .acc_valid  (acc_valid),
  .ext_mem_sel(ext_mem_sel),
  .ext_pci_sel(ext_pci_sel),
  .cs_sel     (cs_sel),
  .cs_conflict(cs_conflict)
);

// File: tb/tb_cs_addr_decoder.sv
module tb_cs_addr_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [11:0] cfg_wbase = '0;
  logic [3:0]  cfg_wsize = '0;
  logic        cfg_wen = 1'b0;
  logic [11:0] cfg_rbase;
  logic [3:0]  cfg_rsize;
  logic        cfg_ren;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        ext_mem_sel = 1'b0;
  logic        ext_pci_sel = 1'b0;
  logic [7:0]  cs_sel;
  logic        cs_conflict;

  always #10 clk = ~clk;

  cs_addr_decoder dut (.*);

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // bench model of the configuration, kept from the requirements
  logic [11:0] m_base [8];
  logic [3:0]  m_size [8];
  logic        m_en   [8];

  logic [8:0]  exp_q [$];
  string       tag_q [$];
  logic        inflight = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] model(input logic [31:0] a, input logic mem,
                                       input logic pci);
    logic [7:0]  h;
    logic [11:0] m;
    int          n;
    h = '0;
    for (int c = 0; c < 8; c++) begin
      if (m_en[c] && m_size[c] <= 4'd10) begin
        m = (12'd1 << m_size[c]) - 12'd1;
        if ((a[31:20] & ~m) == (m_base[c] & ~m)) h[c] = 1'b1;
      end
    end
    n = 0;
    for (int c = 0; c < 8; c++) n += int'(h[c]);
    if (n > 1 || (n == 1 && (mem || pci))) return {1'b1, 8'h00};
    return {1'b0, h};
  endfunction

  // driver: one access per call, expected result pushed to scoreboard
  task automatic access(input logic [31:0] a, input logic mem, input logic pci,
                        input string tag);
    @(negedge clk);
    exp_q.push_back(model(a, mem, pci));
    tag_q.push_back(tag);
    acc_valid   = 1'b1;
    acc_addr    = a;
    ext_mem_sel = mem;
    ext_pci_sel = pci;
  endtask

  task automatic go_idle();
    @(negedge clk);
    acc_valid = 1'b0;
    ext_mem_sel = 1'b0;
    ext_pci_sel = 1'b0;
    cfg_we = 1'b0;
  endtask

  task automatic write_cfg(input int c, input logic [11:0] b, input logic [3:0] s,
                           input logic e);
    @(negedge clk);
    acc_valid = 1'b0;
    cfg_we = 1'b1; cfg_idx = 3'(c); cfg_wbase = b; cfg_wsize = s; cfg_wen = e;
    @(negedge clk);
    cfg_we = 1'b0;
    m_base[c] = b; m_size[c] = s; m_en[c] = e;
  endtask

  task automatic check_readback(input int c, input string req);
    cfg_idx = 3'(c);
    #1;
    check(cfg_rbase == m_base[c] && cfg_rsize == m_size[c] && cfg_ren == m_en[c],
          req, {15'd0, cfg_ren, cfg_rsize, cfg_rbase},
          {15'd0, m_en[c], m_size[c], m_base[c]});
  endtask

  // monitor: compares registered outputs one cycle after each access
  always @(posedge clk) inflight <= acc_valid;

  always @(negedge clk) begin
    if (inflight && exp_q.size() > 0) begin
      logic [8:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({cs_conflict, cs_sel} == e, t, {23'd0, cs_conflict, cs_sel}, {23'd0, e});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 8; c++) begin m_base[c] = '0; m_size[c] = '0; m_en[c] = 1'b0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 / R4: reset state
    check(cs_sel == '0 && !cs_conflict, "R9 outputs after reset",
          {23'd0, cs_conflict, cs_sel}, 32'd0);
    for (int c = 0; c < 8; c++) check_readback(c, "R4 reset config");

    // R4: nothing enabled, nothing selects
    access(32'h0000_0000, 1'b0, 1'b0, "R4 all disabled");
    access(32'h1234_5678, 1'b0, 1'b0, "R4 all disabled");
    go_idle();

    write_cfg(0, 12'h100, 4'd0,  1'b1);
    write_cfg(1, 12'h200, 4'd4,  1'b1);
    write_cfg(2, 12'h400, 4'd10, 1'b1);
    write_cfg(3, 12'h800, 4'd12, 1'b1);
    write_cfg(4, 12'h900, 4'd0,  1'b0);
    write_cfg(7, 12'hC00, 4'd15, 1'b1);
    for (int c = 0; c < 8; c++) check_readback(c, "R8 read-back");

    // R1: low bits ignored, exact 1 MB window
    access(32'h1001_2345, 1'b0, 1'b0, "R1 low bits ignored");
    access(32'h100F_FFFF, 1'b0, 1'b0, "R1 top of 1MB");
    access(32'h1010_0000, 1'b0, 1'b0, "R1 outside 1MB");
    // R2: 16 MB and 1 GB windows
    access(32'h20F0_0000, 1'b0, 1'b0, "R2 top of 16MB");
    access(32'h2100_0000, 1'b0, 1'b0, "R2 past 16MB");
    access(32'h7FF0_0000, 1'b0, 1'b0, "R2 top of 1GB");
    access(32'h3FF0_0000, 1'b0, 1'b0, "R2 below 1GB");
    // R3 / R4
    access(32'h8000_0000, 1'b0, 1'b0, "R3 reserved code 12");
    access(32'hC000_0000, 1'b0, 1'b0, "R3 reserved code 15");
    access(32'h9000_0000, 1'b0, 1'b0, "R4 disabled channel");
    // R7: external claims
    access(32'h2050_0000, 1'b1, 1'b0, "R7 memory clash");
    access(32'h4000_0000, 1'b0, 1'b1, "R7 pci clash");
    access(32'hF000_0000, 1'b1, 1'b1, "R7 ext without hit");
    go_idle();
    @(negedge clk);
    // R5: idle cycle clears outputs
    check(cs_sel == '0 && !cs_conflict, "R5 idle clears",
          {23'd0, cs_conflict, cs_sel}, 32'd0);

    // R6: small window hidden inside the 16 MB window
    write_cfg(5, 12'h205, 4'd0, 1'b1);
    access(32'h2050_0000, 1'b0, 1'b0, "R6 nested overlap");
    access(32'h2060_0000, 1'b0, 1'b0, "R6 outer only");
    access(32'h2050_0000, 1'b0, 1'b0, "R6 nested overlap again");
    go_idle();

    // R8: write and access in one cycle use the old config
    @(negedge clk);
    exp_q.push_back(model(32'hA000_0000, 1'b0, 1'b0));
    tag_q.push_back("R8 same-cycle write uses old config");
    acc_valid = 1'b1; acc_addr = 32'hA000_0000;
    cfg_we = 1'b1; cfg_idx = 3'd6; cfg_wbase = 12'hA00; cfg_wsize = 4'd0; cfg_wen = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0;
    m_base[6] = 12'hA00; m_size[6] = 4'd0; m_en[6] = 1'b1;
    access(32'hA000_0000, 1'b0, 1'b0, "R8 new config active");

    // R5 / R1: sweep of pages back to back
    for (int i = 0; i < 64; i++) begin
      logic [31:0] a;
      a = {$urandom()} ;
      a[31:28] = 4'(i % 16);
      access(a, 1'(i % 7 == 0), 1'(i % 11 == 0), "R5 back-to-back sweep");
    end
    go_idle();
    @(negedge clk);

    // R9: reset mid-run clears configuration
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 8; c++) begin m_base[c] = '0; m_size[c] = '0; m_en[c] = 1'b0; end
    check(cs_sel == '0 && !cs_conflict, "R9 outputs after second reset",
          {23'd0, cs_conflict, cs_sel}, 32'd0);
    for (int c = 0; c < 8; c++) check_readback(c, "R9 config cleared");
    access(32'h1000_0000, 1'b0, 1'b0, "R9 no select after reset");
    go_idle();
    repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule